// File: doc/BRIEF.md
# SPI Serial EEPROM Emulator

This block is a synthesizable SPI slave that answers like a byte-addressed serial EEPROM. A host frames each instruction with its own low period of chip select. A write-enable instruction sets an enable latch. A following write instruction loads up to one page of bytes into a page buffer. When chip select rises at the end of that frame, a timed busy window begins, and during it the buffer is copied into an on-chip RAM array. The host can follow the busy window through the status byte. A read instruction streams bytes out from any starting address.

All SPI inputs are asynchronous to the system clock. They are resynchronised and their edges are detected in the system clock domain. SPI modes 0 and 3 both work: MOSI is taken on the rising SCK edge and MISO changes on the falling edge, most significant bit first. An active-low protect input blocks writes into the top quarter of the array. `ADDR_W` = 15 gives a 32-Kbyte device. The default is a smaller 4-Kbyte array with the same behaviour.

Top module: `spi_eeprom_emu`

## Requirements
- R1: After reset the status byte reads 0x00, and MISO is low while chip select is high.
- R2: Opcode 0x05 returns the status byte {6'b0, enable latch (bit 1), write-in-progress (bit 0)} on the next byte, and again on every further byte of the frame.
- R3: MISO is held low while chip select is high. Transfers work in SPI mode 0 and in mode 3: MOSI is sampled on the rising SCK edge and MISO changes on the falling edge, MSB first.
- R4: A frame holding opcode 0x06 sets the enable latch when chip select rises, so a status read that follows returns 0x02.
- R5: Opcode 0x02 is followed by a 16-bit address sent high byte first, and address bits at and above ADDR_W are ignored. The frame starts a write cycle (status 0x03) only if three conditions hold: the latch is set, at least one whole data byte was sent, and chip select rises on a byte boundary.
- R6: Write-in-progress stays set for BUSY_CYC system clocks, and then it clears together with the enable latch. A write sent while the latch is clear changes nothing and starts no cycle.
- R7: While a cycle is in progress, only opcode 0x05 is honoured. Reads return 0x00 and writes are dropped.
- R8: Write data wraps within the current 64-byte page. When more than 64 bytes are sent, the later byte at a page offset replaces the earlier one.
- R9: While the protect input is low, a write whose page lies in the top quarter of the array is rejected: the latch clears and no cycle starts. Writes to lower addresses still complete.
- R10: Opcode 0x03 plus a 16-bit address returns the stored bytes starting at that address, and the address increments once per byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write protect, active low |
| miso | output | 1 | Serial data out of the block |

## Verification
MISO changes two synchroniser stages plus one register after a falling SCK edge, which is about three system clocks. The bench keeps five system clocks per SCK half period and samples MISO just before it raises SCK, so every bit has settled by then. Write-in-progress rises about three clocks after chip select goes high and holds for BUSY_CYC clocks. The bench therefore reads status straight after a write frame, well inside the window, and again after waiting BUSY_CYC plus a margin. Reads and writes attempted during the window are sent early enough to finish inside it.

// File: rtl/eeprom_emu_pkg.sv
package eeprom_emu_pkg;
  localparam logic [7:0] OP_NONE  = 8'h00;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [1:0] {
    PH_OP   = 2'd0,
    PH_AHI  = 2'd1,
    PH_ALO  = 2'd2,
    PH_DATA = 2'd3
  } frame_phase_t;
endpackage

// File: rtl/eeprom_sync.sv
module eeprom_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= RST_VAL;
          else        stg_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= RST_VAL;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/eeprom_pagebuf.sv
module eeprom_pagebuf #(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  localparam int PAGE = 1 << PAGE_W;

  logic [7:0]      data_q [PAGE];
  logic [PAGE-1:0] vld_q, vld_nxt;

  always_comb begin
    vld_nxt = vld_q;
    if (clr)        vld_nxt = '0;
    else if (wr_en) vld_nxt[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= wr_data;
  end

  assign rd_data   = data_q[rd_idx];
  assign rd_valid  = vld_q[rd_idx];
  assign any_valid = |vld_q;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/spi_eeprom_emu.sv
module spi_eeprom_emu
  import eeprom_emu_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 6,
  parameter int BUSY_CYC    = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  input  logic wp_n,
  output logic miso
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam int PB_W  = ADDR_W - PAGE_W;
  localparam int AH_W  = ADDR_W - 8;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic cs_s, wp_s, sck_s, mosi_s;
  eeprom_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_s), .d({cs_n, wp_n, sck, mosi}),
    .q({cs_s, wp_s, sck_s, mosi_s})
  );

  logic sck_d, cs_d;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin sck_d <= 1'b0; cs_d <= 1'b1; end
    else        begin sck_d <= sck_s; cs_d <= cs_s; end
  end

  logic sck_rise, sck_fall, cs_fall, cs_rise;
  assign sck_rise = sck_s & ~sck_d & ~cs_s;
  assign sck_fall = ~sck_s & sck_d & ~cs_s;
  assign cs_fall  = ~cs_s & cs_d;
  assign cs_rise  = cs_s & ~cs_d;

  // control state
  logic [2:0]        bit_q, bit_nxt;
  frame_phase_t      phase_q, phase_nxt;
  logic [6:0]        sh_q, sh_nxt;
  logic [7:0]        op_q, op_nxt;
  logic [AH_W-1:0]   ahi_q, ahi_nxt;
  logic [ADDR_W-1:0] ptr_q, ptr_nxt;
  logic [7:0]        tx_q, tx_nxt;
  logic              miso_q, miso_nxt;
  logic              wel_q, wel_nxt;
  logic              busy_q, busy_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [PB_W-1:0]   pbase_q, pbase_nxt;

  logic [7:0]        byte_in, status, rdata, pb_rdata;
  logic              byte_done, pb_wr, pb_clr, pb_rd_valid, pb_any;
  logic              wren_end, write_end, commit_ok, mem_we;
  logic [ADDR_W-1:0] addr_in, raddr, mem_waddr;

  assign byte_in   = {sh_q, mosi_s};
  assign byte_done = sck_rise && (bit_q == 3'd7);
  assign addr_in   = {ahi_q, byte_in};
  assign status    = {6'b0, wel_q, busy_q};
  assign raddr     = (phase_q == PH_ALO) ? addr_in : ptr_q;
  assign pb_wr     = byte_done && (phase_q == PH_DATA) && (op_q == OP_WRITE);
  assign pb_clr    = byte_done && (phase_q == PH_OP) && (byte_in == OP_WRITE) && !busy_q;
  assign wren_end  = (op_q == OP_WREN) && (phase_q != PH_OP) && (bit_q == 3'd0);
  assign write_end = (op_q == OP_WRITE) && (phase_q == PH_DATA);
  assign commit_ok = wel_q && (bit_q == 3'd0) && pb_any &&
                     !(!wp_s && (pbase_q[PB_W-1 -: 2] == 2'b11));
  assign mem_we    = busy_q && (int'(cnt_q) < PAGE) && pb_rd_valid;
  assign mem_waddr = {pbase_q, cnt_q[PAGE_W-1:0]};

  always_comb begin
    bit_nxt = bit_q;   phase_nxt = phase_q; sh_nxt = sh_q;     op_nxt = op_q;
    ahi_nxt = ahi_q;   ptr_nxt = ptr_q;     tx_nxt = tx_q;     miso_nxt = miso_q;
    wel_nxt = wel_q;   busy_nxt = busy_q;   cnt_nxt = cnt_q;   pbase_nxt = pbase_q;
    if (busy_q) begin
      if (cnt_q == CNT_W'(BUSY_CYC - 1)) begin
        busy_nxt = 1'b0; wel_nxt = 1'b0; cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
    if (cs_fall) begin
      bit_nxt = '0; phase_nxt = PH_OP; op_nxt = OP_NONE; tx_nxt = '0; miso_nxt = 1'b0;
    end else if (cs_rise) begin
      bit_nxt = '0; phase_nxt = PH_OP; tx_nxt = '0; miso_nxt = 1'b0;
      if (wren_end) begin
        wel_nxt = 1'b1;
      end else if (write_end) begin
        if (commit_ok) begin busy_nxt = 1'b1; cnt_nxt = '0; end
        else           wel_nxt = 1'b0;
      end
    end else begin
      if (sck_fall) begin
        miso_nxt = tx_q[7];
        tx_nxt   = {tx_q[6:0], 1'b0};
      end
      if (sck_rise) begin
        sh_nxt  = byte_in[6:0];
        bit_nxt = bit_q + 3'd1;
      end
      if (byte_done) begin
        if (op_q == OP_RDSR) tx_nxt = status;
        unique case (phase_q)
          PH_OP: begin
            op_nxt    = (busy_q && byte_in != OP_RDSR) ? OP_NONE : byte_in;
            phase_nxt = PH_AHI;
            if (byte_in == OP_RDSR) tx_nxt = status;
          end
          PH_AHI: begin
            ahi_nxt   = byte_in[AH_W-1:0];
            phase_nxt = PH_ALO;
          end
          PH_ALO: begin
            phase_nxt = PH_DATA;
            if (op_q == OP_READ) begin
              tx_nxt  = rdata;
              ptr_nxt = addr_in + 1'b1;
            end else if (op_q == OP_WRITE) begin
              ptr_nxt   = addr_in;
              pbase_nxt = addr_in[ADDR_W-1:PAGE_W];
            end
          end
          PH_DATA: begin
            if (op_q == OP_READ) begin
              tx_nxt  = rdata;
              ptr_nxt = ptr_q + 1'b1;
            end else if (op_q == OP_WRITE) begin
              ptr_nxt = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      bit_q <= '0;   phase_q <= PH_OP; sh_q <= '0;   op_q <= OP_NONE;
      ahi_q <= '0;   ptr_q <= '0;      tx_q <= '0;   miso_q <= 1'b0;
      wel_q <= 1'b0; busy_q <= 1'b0;   cnt_q <= '0;  pbase_q <= '0;
    end else begin
      bit_q <= bit_nxt; phase_q <= phase_nxt; sh_q <= sh_nxt;     op_q <= op_nxt;
      ahi_q <= ahi_nxt; ptr_q <= ptr_nxt;     tx_q <= tx_nxt;     miso_q <= miso_nxt;
      wel_q <= wel_nxt; busy_q <= busy_nxt;   cnt_q <= cnt_nxt;   pbase_q <= pbase_nxt;
    end
  end

  eeprom_pagebuf #(.PAGE_W(PAGE_W)) u_pagebuf (
    .clk(clk), .rst_n(rst_s), .clr(pb_clr), .wr_en(pb_wr),
    .wr_idx(ptr_q[PAGE_W-1:0]), .wr_data(byte_in),
    .rd_idx(cnt_q[PAGE_W-1:0]), .rd_data(pb_rdata),
    .rd_valid(pb_rd_valid), .any_valid(pb_any)
  );

  eeprom_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(pb_rdata),
    .raddr(raddr), .rdata(rdata)
  );

  assign miso = miso_q;
endmodule

// File: rtl/spi_eeprom_emu_chk.sv
module spi_eeprom_emu_chk #(
  parameter int ADDR_W   = 12,
  parameter int BUSY_CYC = 512,
  parameter int CNT_W    = 10
) (
  input logic              clk,
  input logic              rst_s,
  input logic              busy,
  input logic              wel,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic              wp_s,
  input logic              cs_s,
  input logic              miso,
  input logic [CNT_W-1:0]  busy_cnt
);
  // R3: no data driven while deselected
  assert_miso_idle_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (cs_s && $past(cs_s)) |-> !miso);

  // R5: a cycle only begins with the latch set
  assert_cycle_needs_latch_R5: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(busy) |-> wel);

  // R5: the array is written only inside a cycle
  assert_commit_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_s)
    mem_we |-> busy);

  // R6: latch cleared when the cycle ends
  assert_latch_clears_R6: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(busy) |-> !wel);

  // R6: busy counter stays inside its window
  assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_s)
    busy |-> (int'(busy_cnt) < BUSY_CYC));

  // R9: no cycle into the protected quarter while protect is low
  assert_protect_R9: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(busy) |-> ($past(wp_s) || (mem_waddr[ADDR_W-1 -: 2] != 2'b11)));
endmodule

bind spi_eeprom_emu spi_eeprom_emu_chk #(
  .ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_s(rst_s), .busy(busy_q), .wel(wel_q), .mem_we(mem_we),
  .mem_waddr(mem_waddr), .wp_s(wp_s), .cs_s(cs_s), .miso(miso), .busy_cnt(cnt_q)
);

// File: tb/test_spi_eeprom_emu.sv
module test_spi_eeprom_emu;
  localparam int HP   = 5;
  localparam int BUSY = 1500;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso;
  bit   mode3 = 1'b0;
  int   checks = 0, errors = 0;

  logic [7:0] exp_q[$], act_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  spi_eeprom_emu #(.ADDR_W(12), .PAGE_W(6), .BUSY_CYC(BUSY)) i_spi_eeprom_emu (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .wp_n(wp_n), .miso(miso)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: shifts a frame and queues expected response bytes
  task automatic xfer(input logic [7:0] tx[$], input int skip, input logic [7:0] exp[$],
                      input string tag);
    tick(2);
    cs_n = 1'b0;
    tick(HP);
    foreach (tx[i]) begin
      logic [7:0] r;
      r = '0;
      for (int b = 7; b >= 0; b--) begin
        sck = 1'b0; mosi = tx[i][b];
        tick(HP);
        r[b] = miso;
        sck = 1'b1;
        tick(HP);
      end
      if (i >= skip) begin
        act_q.push_back(r); exp_q.push_back(exp[i-skip]); tag_q.push_back(tag);
      end
    end
    if (!mode3) sck = 1'b0;
    tick(HP);
    cs_n = 1'b1;
    tick(4);
  endtask

  task automatic rdsr(input logic [7:0] e, input int n, input string tag);
    logic [7:0] t[$], x[$];
    t.push_back(8'h05);
    for (int k = 0; k < n; k++) begin t.push_back(8'h00); x.push_back(e); end
    xfer(t, 1, x, tag);
  endtask

  task automatic wren();
    logic [7:0] t[$], x[$];
    t.push_back(8'h06);
    xfer(t, 1, x, "none");
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d[$]);
    logic [7:0] t[$], x[$];
    t = {8'h02, a[15:8], a[7:0]};
    foreach (d[i]) t.push_back(d[i]);
    xfer(t, t.size(), x, "none");
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e[$], input string tag);
    logic [7:0] t[$];
    t = {8'h03, a[15:8], a[7:0]};
    foreach (e[i]) t.push_back(8'h00);
    xfer(t, 3, e, tag);
  endtask

  // monitor: pops and compares as bytes arrive
  always @(negedge clk) begin
    if (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual %02h expected %02h", t, a, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] big[$];
    tick(5); rst_n = 1'b1; tick(8);
    checks++;
    if (miso !== 1'b0) begin errors++; $display("FAIL R1 actual %b expected 0", miso); end
    rdsr(8'h00, 1, "R1 reset status");

    wren();
    rdsr(8'h02, 1, "R4 latch set");
    wr(16'h0010, {8'hA1, 8'hB2, 8'hC3, 8'hD4});
    rdsr(8'h03, 2, "R2 R5 busy status repeated");
    tick(BUSY + 20);
    rdsr(8'h00, 1, "R6 cycle done");
    rd(16'h0010, {8'hA1, 8'hB2, 8'hC3, 8'hD4}, "R10 sequential read");
    rd(16'hF010, {8'hA1, 8'hB2}, "R5 upper address bits ignored");

    wr(16'h0010, {8'hEE});
    rdsr(8'h00, 1, "R6 no latch no cycle");
    rd(16'h0010, {8'hA1}, "R6 data unchanged");

    wren();
    wr(16'h007E, {8'h11, 8'h22, 8'h33, 8'h44});
    tick(BUSY + 20);
    rd(16'h007E, {8'h11, 8'h22}, "R8 page tail");
    rd(16'h0040, {8'h33, 8'h44}, "R8 page wrap");

    for (int k = 0; k < 66; k++) big.push_back(8'(k));
    wren();
    wr(16'h0100, big);
    tick(BUSY + 20);
    rd(16'h0100, {8'h40, 8'h41, 8'h02}, "R8 later byte wins");

    wren();
    wr(16'h0C20, {8'hA5});
    tick(BUSY + 20);
    wp_n = 1'b0;
    wren();
    wr(16'h0C20, {8'h5A});
    rdsr(8'h00, 1, "R9 protected write rejected");
    rd(16'h0C20, {8'hA5}, "R9 protected data kept");
    wren();
    wr(16'h0200, {8'h77});
    rdsr(8'h03, 1, "R9 low address allowed");
    tick(BUSY + 20);
    rd(16'h0200, {8'h77}, "R9 low address written");
    wp_n = 1'b1;

    wren();
    wr(16'h0300, {8'hC1});
    rd(16'h0010, {8'h00}, "R7 read ignored while busy");
    wr(16'h0010, {8'h99});
    rdsr(8'h03, 1, "R7 status still honoured");
    tick(BUSY + 20);
    rd(16'h0010, {8'hA1}, "R7 write dropped while busy");
    rd(16'h0300, {8'hC1}, "R7 cycle data committed");

    mode3 = 1'b1; sck = 1'b1; tick(4);
    rd(16'h0010, {8'hA1, 8'hB2, 8'hC3, 8'hD4}, "R3 mode 3 read");
    rdsr(8'h00, 1, "R3 mode 3 status");
    mode3 = 1'b0; sck = 1'b0; tick(4);

    wait (act_q.size() == 0);
    tick(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule